// File: doc/BRIEF.md
# NAND Sector Hamming Parity Accumulator

This block builds a column/row Hamming parity code over one flash sector while the sector's data streams past, either toward a NAND device during programming or back from it during a read. Each data beat carries one byte, or two bytes in 16-bit column mode. The block tracks the byte address of every byte it absorbs. For each of the twelve bits of the combined index {byte address, bit number} it keeps two parities: one over the data bits whose index bit is 0 and one over those whose index bit is 1.

Software programs the enable, the column width and a sector-length field, clears the accumulator, and then lets the data flow. When the programmed number of bytes has been absorbed, the block raises a done flag and freezes the code. The code is presented two ways. One is a 28-bit result word with the "zero-side" parities in the low half and the "one-side" parities in the high half. The other is a packed 3-byte form suitable for the spare area. On a later read, comparing the stored packed code against a freshly computed one gives the syndrome that locates a single flipped bit.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, `res_word`, `spare_code` and `sector_done` are all zero.
- R2: For every data bit set at byte address a (9 bits) and bit position b (3 bits), the 12-bit index i = {a, b} is formed. For each k in 0..11, the zero-side parity Z[k] is toggled when i[k] = 0, and the one-side parity O[k] is toggled when i[k] = 1. As a consequence, Z XOR O is either all zeros or all ones.
- R3: `res_word[11:0]` holds Z[11:0], with bit k holding the parity for index bit k. `res_word[27:16]` holds O[11:0] in the same order. `res_word[15:12]` is always zero.
- R4: `spare_code[7:0]` = `res_word[7:0]` and `spare_code[15:8]` = `res_word[23:16]`. `spare_code[23:16]` carries `res_word[11:8]` in its low nibble and `res_word[27:24]` in its high nibble.
- R5: With `cfg_wide` = 1, each beat supplies two bytes. `din[7:0]` is taken at the current byte address and `din[15:8]` at the next one. A sector fed this way yields the same code as the same bytes fed one per beat with `cfg_wide` = 0, which uses `din[7:0]` only.
- R6: A beat is absorbed only in a cycle where both `cfg_en` and `din_vld` are high. In any other cycle the code and the done flag hold their values.
- R7: `ctl_clear` zeroes the code, the byte address and the done flag on the next edge. This takes priority over a beat presented in the same cycle.
- R8: The sector length is 2 × (`cfg_size` + 1) bytes. `sector_done` rises on the edge that absorbs the last byte of the sector and is low before that edge.
- R9: While `sector_done` is high, further beats are ignored until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Accumulation enable |
| cfg_wide | input | 1 | 1 = two bytes per beat (16-bit column), 0 = one byte |
| cfg_size | input | 8 | Sector length field: bytes = 2 × (value + 1) |
| ctl_clear | input | 1 | Clear code, byte address and done flag |
| din_vld | input | 1 | Data beat valid |
| din | input | 16 | Data beat, low byte first |
| res_word | output | 28 | Split parity word: zero-side in 11:0, one-side in 27:16 |
| spare_code | output | 24 | Packed 3-byte code for the spare area |
| sector_done | output | 1 | Sector complete, code frozen |

## Verification
The cycle-by-cycle properties are checked on every cycle: the empty gap in the result word, the packing of the 3-byte code, the complementary relation between the two parity halves, holding the code on idle cycles, clearing, and freezing after completion. Only the bench's scenarios can show that the parities land on the right index bits and that the sector ends after exactly the programmed number of bytes. They are also the only way to show that byte-wide and 16-bit feeds of the same data agree. The bench establishes these by comparing against a bit-level model on random sectors, on an all-ones sector and on a single set bit.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int BIT_W   = 3;               // bit-in-byte index width
    localparam int ADDR_W  = 9;               // byte address width (512-byte sector)
    localparam int NPAR    = BIT_W + ADDR_W;  // parity pairs
    localparam int ODD_OFS = 16;              // one-side parities start here
    localparam int RES_W   = ODD_OFS + NPAR;  // 28-bit result word
    localparam int CODE_W  = 24;
    localparam int CNT_W   = ADDR_W + 1;
    localparam int SIZE_W  = ADDR_W - 1;

    typedef logic [NPAR-1:0] par_t;

    typedef struct packed {
        par_t             zero_side;
        par_t             one_side;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } acc_t;
endpackage

// File: rtl/nand_ecc_lane.sv
module nand_ecc_lane
    import nand_ecc_pkg::*;
(
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              lane_use,
    output par_t              zero_out,
    output par_t              one_out
);
    logic row_par;

    always_comb begin
        zero_out = '0;
        one_out  = '0;
        row_par  = ^byte_in;
        for (int k = 0; k < BIT_W; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) != 0) one_out[k]  = one_out[k]  ^ byte_in[b];
                else                     zero_out[k] = zero_out[k] ^ byte_in[b];
            end
        end
        for (int j = 0; j < ADDR_W; j++) begin
            if (byte_addr[j]) one_out[BIT_W+j]  = row_par;
            else              zero_out[BIT_W+j] = row_par;
        end
        if (!lane_use) begin
            zero_out = '0;
            one_out  = '0;
        end
    end
endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
    import nand_ecc_pkg::*;
(
    input  logic [RES_W-1:0]  res_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb begin
        code_out[7:0]   = res_in[7:0];
        code_out[15:8]  = res_in[ODD_OFS+7:ODD_OFS];
        code_out[19:16] = res_in[11:8];
        code_out[23:20] = res_in[ODD_OFS+11:ODD_OFS+8];
    end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wide,
    input  logic [7:0]        cfg_size,
    input  logic              ctl_clear,
    input  logic              din_vld,
    input  logic [DATA_W-1:0] din,
    output logic [27:0]       res_word,
    output logic [23:0]       spare_code,
    output logic              sector_done
);
    localparam int LANES = DATA_W / 8;

    acc_t acc_d, acc_q;
    par_t lane_zero [LANES];
    par_t lane_one  [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr = acc_q.cnt[ADDR_W-1:0] + ADDR_W'(l);
        nand_ecc_lane i_lane (
            .byte_in   (din[8*l +: 8]),
            .byte_addr (lane_addr),
            .lane_use  ((l == 0) || cfg_wide),
            .zero_out  (lane_zero[l]),
            .one_out   (lane_one[l])
        );
    end

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_next;
    logic             take;
    par_t             beat_zero, beat_one;

    always_comb begin
        acc_d     = acc_q;
        limit     = (CNT_W'(cfg_size[SIZE_W-1:0]) + CNT_W'(1)) << 1;
        step      = cfg_wide ? CNT_W'(2) : CNT_W'(1);
        cnt_next  = acc_q.cnt + step;
        take      = cfg_en && din_vld && !acc_q.done;
        beat_zero = '0;
        beat_one  = '0;
        for (int l = 0; l < LANES; l++) begin
            beat_zero = beat_zero ^ lane_zero[l];
            beat_one  = beat_one  ^ lane_one[l];
        end
        if (ctl_clear) begin
            acc_d = '0;
        end else if (take) begin
            acc_d.zero_side = acc_q.zero_side ^ beat_zero;
            acc_d.one_side  = acc_q.one_side  ^ beat_one;
            acc_d.cnt       = cnt_next;
            acc_d.done      = (cnt_next >= limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign res_word    = {acc_q.one_side, 4'b0000, acc_q.zero_side};
    assign sector_done = acc_q.done;

    nand_ecc_pack i_pack (
        .res_in   (res_word),
        .code_out (spare_code)
    );
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        ctl_clear,
    input logic        din_vld,
    input logic [27:0] res_word,
    input logic [23:0] spare_code,
    input logic        sector_done
);
    logic [11:0] side_xor;
    assign side_xor = res_word[11:0] ^ res_word[27:16];

    // R3: gap between the halves stays empty
    a_r3_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_word[15:12] == 4'h0);

    // R4: packed code follows the result word
    a_r4_pack_layout: assert property (@(posedge clk) disable iff (!rst_n)
        spare_code == {res_word[27:24], res_word[11:8], res_word[23:16], res_word[7:0]});

    // R2: both sides of every pair cover the same bits
    a_r2_side_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (side_xor == 12'h000) || (side_xor == 12'hFFF));

    // R6: no beat, no change
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_en && din_vld) && !ctl_clear) |=> ($stable(res_word) && $stable(sector_done)));

    // R7: clear empties everything
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clear |=> (res_word == 28'h0 && !sector_done));

    // R9: completed sector is frozen
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && !ctl_clear) |=> (sector_done && $stable(res_word)));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .ctl_clear   (ctl_clear),
    .din_vld     (din_vld),
    .res_word    (res_word),
    .spare_code  (spare_code),
    .sector_done (sector_done)
);

// File: tb/test_nand_ecc_acc.sv
`timescale 1ns/1ps
module test_nand_ecc_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [7:0]  cfg_size = 8'd255;
    logic        ctl_clear = 1'b0;
    logic        din_vld = 1'b0;
    logic [15:0] din = 16'h0;
    logic [27:0] res_word;
    logic [23:0] spare_code;
    logic        sector_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [7:0] mem [512];

    always #5 clk = ~clk;

    nand_ecc_acc i_nand_ecc_acc (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wide(cfg_wide),
        .cfg_size(cfg_size), .ctl_clear(ctl_clear), .din_vld(din_vld), .din(din),
        .res_word(res_word), .spare_code(spare_code), .sector_done(sector_done)
    );

    function automatic logic [27:0] model(int n);
        logic [11:0] z = '0;
        logic [11:0] o = '0;
        for (int a = 0; a < n; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[a][b]) begin
                    logic [11:0] idx = {a[8:0], b[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (idx[k]) o[k] = ~o[k];
                        else        z[k] = ~z[k];
                    end
                end
            end
        end
        return {o, 4'h0, z};
    endfunction

    function automatic logic [23:0] pack(logic [27:0] r);
        return {r[27:24], r[11:8], r[23:16], r[7:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk) ctl_clear = 1'b1;
        @(negedge clk) ctl_clear = 1'b0;
    endtask

    // feed n bytes of mem; gaps inserts idle cycles with junk on din
    task automatic feed(int n, bit wide, bit gaps, string req);
        cfg_wide = wide;
        cfg_size = 8'(n / 2 - 1);
        for (int i = 0; i < n; i += (wide ? 2 : 1)) begin
            if (gaps && ($urandom % 3 == 0)) begin
                @(negedge clk);
                din_vld = 1'b0;
                din = 16'($urandom);
            end
            @(negedge clk);
            if (i == n - (wide ? 2 : 1)) check({req, " R8 done low before last"}, 32'(sector_done), 32'd0);
            din_vld = 1'b1;
            din = wide ? {mem[i+1], mem[i]} : {8'($urandom), mem[i]};
        end
        @(negedge clk);
        din_vld = 1'b0;
        check({req, " R8 done"}, 32'(sector_done), 32'd1);
        check({req, " R2 R3 result"}, 32'(res_word), 32'(model(n)));
        check({req, " R4 packed"}, 32'(spare_code), 32'(pack(model(n))));
    endtask

    initial begin
        void'($urandom(32'd7321));
        #1;
        check("R1 reset res", 32'(res_word), 32'd0);
        check("R1 reset code", 32'(spare_code), 32'd0);
        check("R1 reset done", 32'(sector_done), 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_en = 1'b1;

        // random full sector, byte mode then 16-bit mode (R5)
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        do_clear();
        feed(512, 1'b0, 1'b1, "R2 rand byte");
        do_clear();
        feed(512, 1'b1, 1'b0, "R5 rand wide");

        // R9: extra beats after completion are ignored
        repeat (3) begin
            @(negedge clk) din_vld = 1'b1; din = 16'($urandom);
        end
        @(negedge clk) din_vld = 1'b0;
        check("R9 frozen res", 32'(res_word), 32'(model(512)));
        check("R9 done held", 32'(sector_done), 32'd1);

        // all ones: every parity covers an even count
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        do_clear();
        feed(512, 1'b1, 1'b1, "R2 all ones");
        check("R2 all ones zero", 32'(res_word), 32'd0);

        // single set bit at byte 300, bit 5 -> index 0x965
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[300] = 8'h20;
        do_clear();
        feed(512, 1'b0, 1'b0, "R2 single bit");
        check("R2 single bit literal", 32'(res_word), 32'h0965069A);

        // short sectors (R8)
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        do_clear();
        feed(8, 1'b0, 1'b1, "R8 size 8 byte");
        do_clear();
        feed(2, 1'b1, 1'b0, "R8 size 2 wide");
        do_clear();
        feed(64, 1'b1, 1'b1, "R8 size 64 wide");

        // R6: enable low ignores beats; valid low ignores data
        do_clear();
        cfg_en = 1'b0;
        cfg_size = 8'd0;
        cfg_wide = 1'b0;
        repeat (4) begin
            @(negedge clk) din_vld = 1'b1; din = 16'hFFFF;
        end
        @(negedge clk) din_vld = 1'b0;
        check("R6 disabled res", 32'(res_word), 32'd0);
        check("R6 disabled done", 32'(sector_done), 32'd0);
        cfg_en = 1'b1;
        repeat (4) begin
            @(negedge clk) din = 16'($urandom);
        end
        @(negedge clk);
        check("R6 no valid res", 32'(res_word), 32'd0);

        // R7: clear wins over a beat in the same cycle; address restarts
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        do_clear();
        feed(16, 1'b0, 1'b0, "R7 prefill");
        @(negedge clk) begin ctl_clear = 1'b1; din_vld = 1'b1; din = 16'h00FF; end
        @(negedge clk) begin ctl_clear = 1'b0; din_vld = 1'b0; end
        check("R7 clear res", 32'(res_word), 32'd0);
        check("R7 clear done", 32'(sector_done), 32'd0);
        feed(16, 1'b1, 1'b0, "R7 restart");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule